// File: doc/BRIEF.md
# Greyscale Temporal Dither Modulator

This block drives a one-bit-per-pixel monochrome panel so that a sequence of frames shows grey levels. Every pixel owns an 8-bit intensity (0 to 128) and an 8-bit phase byte, both held in internal storage. On each frame pass the block sends the top bit of each pixel's phase over a valid/ready serial bit stream, in ascending pixel order and in groups of eight pixels. After a pixel's bit has left, its phase is updated to `(phase | 0x80) - intensity` modulo 256 and stored back for the next frame. The fraction of frames in which a pixel sends 0 therefore tracks its intensity over 128.

Software loads intensities through a simple write port while the block is idle. It then pulses `start` with the number of 8-pixel blocks to send. Phases are kept in words of several pixels, with the lowest pixel address in the most significant byte. A whole word is updated in one cycle after its last bit has been accepted.

Top module: `grey_dither_mod`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every phase byte and every intensity is 0, and `busy`, `out_valid`, `out_bit`, `out_grp_end`, `out_last` and `done` are all 0.
- R2: A write with `wr_en` high while idle stores `wr_data` as the intensity of pixel `wr_addr`. Values above 128 are stored as 128.
- R3: `start` while idle with `blocks` non-zero begins a pass of 8*min(`blocks`, MAX_BLOCKS) bits, and `busy` is 1 from the next cycle. `start` with `blocks` equal to 0 does nothing.
- R4: Bit k of a pass (counting from 0) is bit 7 of the phase byte of pixel address k at the start of that pass.
- R5: Once a pixel's bit has been accepted, its phase becomes `((old | 0x80) - intensity) mod 256` and serves as the starting phase of the next pass.
- R6: `out_grp_end` is 1 exactly on bits whose index k satisfies k mod 8 = 7. `out_last` is 1 only on the final bit of the pass.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` keeps its value in the next cycle.
- R8: In the cycle after the final bit is accepted, `busy`, `out_valid` and `out_bit` are 0 and `done` is 1 for exactly one cycle.
- R9: `wr_en` and `start` asserted while `busy` is 1 have no effect. This includes the cycle in which the final bit is accepted.
- R10: Starting from reset, over 128 consecutive passes each pixel sends a 0 either I or I+1 times, where I is its stored intensity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears phases and intensities |
| wr_en | input | 1 | Intensity write strobe (idle only) |
| wr_addr | input | ADDR_W | Pixel address of the write |
| wr_data | input | 8 | Intensity value, saturated to 128 |
| start | input | 1 | Begin a frame pass |
| blocks | input | BLK_W | Number of 8-pixel blocks in the pass |
| busy | output | 1 | Pass in progress |
| out_valid | output | 1 | Serial bit available |
| out_ready | input | 1 | Receiver accepts the bit this cycle |
| out_bit | output | 1 | Pixel on/off bit (phase bit 7) |
| out_grp_end | output | 1 | Marks the eighth bit of each block |
| out_last | output | 1 | Marks the final bit of the pass |
| done | output | 1 | One-cycle pulse after the pass ends |

## Verification
A host write, a host `start`, the acceptance of the final bit and the write-back of the final phase word can all land on the same clock edge. The bench provokes this by raising `wr_en` and `start` together with `out_ready` on the last bit of a pass. It then confirms that `busy` falls in the next cycle, which shows no restart took place. It also confirms that later passes follow a model in which the intensity was never changed and every phase was updated. Back-pressure patterns check that held bits neither repeat nor skip phase updates.

// File: rtl/gdm_pkg.sv
package gdm_pkg;

   localparam int PIX_BITS = 8;
   localparam logic [PIX_BITS-1:0] INT_CEIL = 8'd128;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   function automatic logic [PIX_BITS-1:0] sat_int(input logic [PIX_BITS-1:0] v);
      return (v > INT_CEIL) ? INT_CEIL : v;
   endfunction

endpackage

// File: rtl/gdm_phase_update.sv
module gdm_phase_update #(
   parameter int PPW      = 4,
   parameter bit WIDE_SUB = 1'b1
) (
   input  logic [PPW*8-1:0] old_ph,
   input  logic [PPW*8-1:0] ints,
   output logic [PPW*8-1:0] new_ph
);

   localparam logic [PPW*8-1:0] SIGN_MASK = {PPW{8'h80}};

   generate
      if (WIDE_SUB) begin : g_wide
         // one carry chain across the word; intensities <= 128 mean no lane borrows
         assign new_ph = (old_ph | SIGN_MASK) - ints;
      end else begin : g_lane
         for (genvar l = 0; l < PPW; l++) begin : g_l
            assign new_ph[l*8 +: 8] = (old_ph[l*8 +: 8] | 8'h80) - ints[l*8 +: 8];
         end
      end
   endgenerate

endmodule

// File: rtl/gdm_pixel_store.sv
module gdm_pixel_store
   import gdm_pkg::*;
#(
   parameter int NWORDS = 8,
   parameter int PPW    = 4,
   parameter int WIDX_W = 3,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_we,
   input  logic [ADDR_W-1:0] int_addr,
   input  logic [7:0]        int_val,
   input  logic [WIDX_W-1:0] rd_idx,
   output logic [PPW*8-1:0]  ph_rd,
   output logic [PPW*8-1:0]  int_rd,
   input  logic              ph_we,
   input  logic [PPW*8-1:0]  ph_wd
);

   logic [PPW*8-1:0] ph_mem  [NWORDS];
   logic [PPW*8-1:0] int_mem [NWORDS];

   int wr_word;
   int wr_lsb;
   logic [7:0] int_sat;

   always_comb begin
      wr_word = int'(int_addr) / PPW;
      // lowest address of a word sits in its most significant byte
      wr_lsb  = (PPW - 1 - (int'(int_addr) % PPW)) * 8;
      int_sat = sat_int(int_val);
   end

   assign ph_rd  = ph_mem[rd_idx];
   assign int_rd = int_mem[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORDS; i++) begin
            ph_mem[i]  <= '0;
            int_mem[i] <= '0;
         end
      end else begin
         if (ph_we) ph_mem[rd_idx] <= ph_wd;
         if (int_we && wr_word < NWORDS) int_mem[wr_word][wr_lsb +: 8] <= int_sat;
      end
   end

endmodule

// File: rtl/gdm_scan_ctrl.sv
module gdm_scan_ctrl
   import gdm_pkg::*;
#(
   parameter int MAX_BLOCKS = 4,
   parameter int PPW        = 4,
   parameter int BLK_W      = 4,
   parameter int WIDX_W     = 3,
   parameter int LANE_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BLK_W-1:0]  blocks,
   input  logic              out_ready,
   output logic [WIDX_W-1:0] word_idx,
   output logic [LANE_W-1:0] lane,
   output logic              word_done,
   output logic              out_valid,
   output logic              out_last,
   output logic              out_grp_end,
   output logic              busy,
   output logic              done
);

   localparam int WPB = 8 / PPW;

   scan_state_e       state_q;
   logic [WIDX_W-1:0] widx_q, last_q, last_calc;
   logic [LANE_W-1:0] lane_q;
   logic              done_q;
   logic              run, accept, lane_end, at_last;
   int                nblk;

   always_comb begin
      nblk      = (int'(blocks) > MAX_BLOCKS) ? MAX_BLOCKS : int'(blocks);
      last_calc = WIDX_W'(nblk * WPB - 1);
   end

   assign run       = (state_q == SCAN_RUN);
   assign accept    = run && out_ready;
   assign lane_end  = (lane_q == LANE_W'(PPW - 1));
   assign at_last   = (widx_q == last_q);
   assign word_done = accept && lane_end;

   assign word_idx    = widx_q;
   assign lane        = lane_q;
   assign out_valid   = run;
   assign busy        = run;
   assign done        = done_q;
   assign out_last    = run && lane_end && at_last;
   assign out_grp_end = run && lane_end && (((int'(widx_q) + 1) % WPB) == 0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SCAN_IDLE;
         widx_q  <= '0;
         last_q  <= '0;
         lane_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SCAN_IDLE: begin
               if (start && blocks != '0) begin
                  state_q <= SCAN_RUN;
                  widx_q  <= '0;
                  lane_q  <= '0;
                  last_q  <= last_calc;
               end
            end
            SCAN_RUN: begin
               if (accept) begin
                  if (lane_end) begin
                     lane_q <= '0;
                     if (at_last) begin
                        state_q <= SCAN_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        widx_q <= widx_q + 1'b1;
                     end
                  end else begin
                     lane_q <= lane_q + 1'b1;
                  end
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end

   // R7: held bit stays offered and unchanged
   a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(lane) && $stable(word_idx)));

   // R6: the final bit closes the burst
   a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

   // R8: completion pulse lasts one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: a valid start while idle opens a pass
   a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && blocks != '0) |=> busy);

   // R3: a zero-block start leaves the block idle
   a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && blocks == '0) |=> !busy);

endmodule

// File: rtl/grey_dither_mod.sv
module grey_dither_mod
   import gdm_pkg::*;
#(
   parameter int MAX_BLOCKS = 4,
   parameter int PPW        = 4,
   parameter int BLK_W      = 4,
   parameter bit WIDE_SUB   = 1'b1,
   parameter int ADDR_W     = $clog2(MAX_BLOCKS * 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              start,
   input  logic [BLK_W-1:0]  blocks,
   output logic              busy,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_bit,
   output logic              out_grp_end,
   output logic              out_last,
   output logic              done
);

   localparam int NPIX   = MAX_BLOCKS * 8;
   localparam int NWORDS = NPIX / PPW;
   localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int LANE_W = (PPW > 1) ? $clog2(PPW) : 1;

   generate
      if (!(PPW == 1 || PPW == 2 || PPW == 4 || PPW == 8)) begin : g_bad_ppw
         $error("PPW must divide 8");
      end
      if (MAX_BLOCKS < 1) begin : g_bad_blocks
         $error("MAX_BLOCKS must be at least 1");
      end
      if ((1 << ADDR_W) < NPIX) begin : g_bad_addr
         $error("ADDR_W too narrow for pixel count");
      end
      if ((1 << BLK_W) <= 1) begin : g_bad_blkw
         $error("BLK_W too narrow");
      end
   endgenerate

   logic [WIDX_W-1:0] word_idx;
   logic [LANE_W-1:0] lane;
   logic              word_done;
   logic [PPW*8-1:0]  ph_rd, int_rd, ph_new;
   int                bit_pos;

   gdm_scan_ctrl #(
      .MAX_BLOCKS(MAX_BLOCKS), .PPW(PPW), .BLK_W(BLK_W),
      .WIDX_W(WIDX_W), .LANE_W(LANE_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .blocks(blocks),
      .out_ready(out_ready), .word_idx(word_idx), .lane(lane),
      .word_done(word_done), .out_valid(out_valid), .out_last(out_last),
      .out_grp_end(out_grp_end), .busy(busy), .done(done)
   );

   gdm_pixel_store #(
      .NWORDS(NWORDS), .PPW(PPW), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .int_we(wr_en && !busy),
      .int_addr(wr_addr), .int_val(wr_data), .rd_idx(word_idx),
      .ph_rd(ph_rd), .int_rd(int_rd), .ph_we(word_done), .ph_wd(ph_new)
   );

   gdm_phase_update #(.PPW(PPW), .WIDE_SUB(WIDE_SUB)) u_upd (
      .old_ph(ph_rd), .ints(int_rd), .new_ph(ph_new)
   );

   // lane 0 is the most significant byte of the word
   always_comb bit_pos = (PPW - 1 - int'(lane)) * 8 + 7;
   assign out_bit = busy ? ph_rd[bit_pos] : 1'b0;

   logic int_in_range;
   always_comb begin
      int_in_range = 1'b1;
      for (int l = 0; l < PPW; l++)
         if (int_rd[l*8 +: 8] > INT_CEIL) int_in_range = 1'b0;
   end

   // R2: stored intensities never exceed the ceiling
   a_r2_int_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> int_in_range);

   // R8: idle lines stay quiet
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_valid && !out_bit && !out_last && !out_grp_end));

   // R7: a held bit keeps its value
   a_r7_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(out_bit));

endmodule

// File: tb/grey_dither_mod_test.sv
module grey_dither_mod_test;

   localparam int MAXB = 4;
   localparam int NPIX = MAXB * 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       start = 1'b0;
   logic [3:0] blocks = '0;
   logic       out_ready = 1'b0;
   logic       busy, out_valid, out_bit, out_grp_end, out_last, done;

   always #2 clk = ~clk;

   grey_dither_mod uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .blocks(blocks), .busy(busy),
      .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
      .out_grp_end(out_grp_end), .out_last(out_last), .done(done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] m_int [NPIX];
   logic [7:0] m_ph  [NPIX];
   int         zeros [NPIX];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NPIX; i++) begin
         m_int[i] = 8'd0; m_ph[i] = 8'd0; zeros[i] = 0;
      end
   endtask

   task automatic write_pix(input int a, input int v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(v);
      @(negedge clk);
      wr_en = 1'b0;
      m_int[a] = (v > 128) ? 8'd128 : 8'(v);
   endtask

   // stall: 0 none, 1 periodic back-pressure; inject: host traffic on final bit
   task automatic run_pass(input int nreq, input int stall, input bit inject, input bit quiet);
      int n, k, cyc;
      bit prev_held, prev_bit;
      n = ((nreq > MAXB) ? MAXB : nreq) * 8;
      @(negedge clk);
      start = 1'b1; blocks = 4'(nreq);
      @(negedge clk);
      start = 1'b0;
      if (n == 0) begin
         repeat (3) begin
            check(!busy && !out_valid, "R3 zero-block start ignored", busy, 0);
            @(negedge clk);
         end
         return;
      end
      if (!quiet) check(busy, "R3 busy after start", busy, 1);
      k = 0; cyc = 0; prev_held = 1'b0; prev_bit = 1'b0;
      while (k < n && cyc < 5000) begin
         wr_en = 1'b0; start = 1'b0;
         if (!out_valid) begin
            check(0, "R3 valid dropped early", k, n);
            break;
         end
         if (prev_held) check(out_bit == prev_bit, "R7 held bit stable", out_bit, prev_bit);
         check(out_bit == m_ph[k][7], "R4 bit equals phase sign", out_bit, m_ph[k][7]);
         if (!quiet) begin
            check(out_grp_end == (k % 8 == 7), "R6 group end", out_grp_end, k % 8 == 7);
            check(out_last == (k == n - 1), "R6 last flag", out_last, k == n - 1);
         end
         out_ready = (stall == 1) ? (cyc % 3 != 1) : 1'b1;
         if (inject && k == n - 1) begin
            out_ready = 1'b1;
            wr_en = 1'b1; wr_addr = 5'd0; wr_data = 8'd77;
            start = 1'b1; blocks = 4'd1;
         end
         prev_held = !out_ready;
         prev_bit  = out_bit;
         if (out_ready) begin
            if (out_bit == 1'b0) zeros[k]++;
            m_ph[k] = (m_ph[k] | 8'h80) - m_int[k];
            k++;
         end
         cyc++;
         @(negedge clk);
      end
      wr_en = 1'b0; start = 1'b0; out_ready = 1'b0;
      check(!busy && !out_valid && !out_bit, "R8 idle after final bit", busy, 0);
      check(done, "R8 done pulse", done, 1);
      if (inject) check(!busy, "R9 start on final cycle ignored", busy, 0);
      @(negedge clk);
      check(!done && !busy, "R8 done lasts one cycle", done, 0);
   endtask

   task automatic t_reset();
      do_reset();
      check(!busy && !out_valid && !out_bit && !out_grp_end && !out_last && !done,
            "R1 reset outputs idle", busy, 0);
      run_pass(MAXB, 0, 1'b0, 1'b0);   // R1 phases cleared: every bit 0
      run_pass(MAXB, 0, 1'b0, 1'b0);   // R5 0x80 after zero intensity
   endtask

   task automatic t_pattern();
      do_reset();
      for (int i = 0; i < NPIX; i++) write_pix(i, (i * 37 + 5) % 129);
      write_pix(5, 200);                // R2 saturation to 128
      write_pix(6, 255);                // R2 saturation to 128
      for (int f = 0; f < 4; f++) run_pass(MAXB, f % 2, 1'b0, 1'b0);
   endtask

   task automatic t_block_count();
      run_pass(0, 0, 1'b0, 1'b0);       // R3 zero blocks
      run_pass(1, 0, 1'b0, 1'b0);       // R3 single block
      run_pass(9, 1, 1'b0, 1'b0);       // R3 clamp to MAX_BLOCKS
      run_pass(3, 0, 1'b0, 1'b0);
   endtask

   task automatic t_busy_collision();
      run_pass(2, 0, 1'b1, 1'b0);       // R9 write+start on last accept
      run_pass(MAXB, 0, 1'b0, 1'b0);    // R9 model kept old intensity
      run_pass(MAXB, 1, 1'b0, 1'b0);
   endtask

   task automatic t_long_run();
      do_reset();
      for (int i = 0; i < 16; i++) write_pix(i, (i * 128) / 15);
      for (int f = 0; f < 128; f++) run_pass(2, 0, 1'b0, 1'b1);
      for (int i = 0; i < 16; i++)
         check(zeros[i] == int'(m_int[i]) || zeros[i] == int'(m_int[i]) + 1,
               "R10 zero count tracks intensity", zeros[i], m_int[i]);
   endtask

   initial begin
      t_reset();
      t_pattern();
      t_block_count();
      t_busy_collision();
      t_long_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule